// File: doc/BRIEF.md
# Particle Filter Systematic Resampler

This block performs the selection step of systematic resampling in a particle filter. A pass begins with weight intake: normalized particle weights arrive one per handshake on a valid/ready stream. Each accepted weight is added to a running total, and that total is written into an internal prefix-sum table. Once the table holds N entries, the pass moves on to selection. A pseudo-random generator supplies one draw. The draw sets the first threshold in [0, 1/N). Each later threshold is one step of 1/N above the one before.

For each output slot, a search pointer walks the prefix-sum table. It moves forward while the threshold is greater than the table entry at the pointer. The pointer stops at the first entry that covers the threshold, or at the last particle. The particle index found this way goes out on a second valid/ready stream. A downstream stage may hold back an index by keeping `idx_ready` low, and the index then waits unchanged. After N indices have been taken, a one-cycle `reg_init` pulse tells the following regularization stage to begin. Intake stays closed for the whole pass.

The generator's state survives from pass to pass. It can be reloaded at any time with a seed.

Top module: `pf_resampler`

## Requirements
- R1: A weight is accepted when `w_valid` and `w_ready` are both high at a rising clock edge. The k-th accepted weight of a pass is added to the running sum, and that sum becomes table entry k-1. Selection starts after the N-th weight, with N = 2^LOG2N. `w_ready` is high after reset.
- R2: `busy` is high from the cycle after the N-th weight until the end of the pass. While `busy` is high, `w_ready` is low, and a weight offered then is neither stored nor counted.
- R3: Weights and thresholds are unsigned values on a scale where 1.0 = 2^(CUM_W-1). For each slot, the pointer advances while U > table[pointer] and the pointer is below N-1. The emitted index is where the pointer stops.
- R4: Within a pass the search pointer never moves backward. Each pass starts the pointer at 0.
- R5: The pointer stops at N-1 even when the threshold is above every table entry, for example when the weights sum to less than 1.0.
- R6: While `idx_valid` is high and `idx_ready` is low, `idx_valid` stays high and `idx_data` keeps its value.
- R7: Each pass emits exactly N indices. `reg_init` is high for exactly one cycle, in the cycle after the handshake of the last index, and `busy` drops in that same cycle.
- R8: The first threshold is r >> LOG2N, where r is bits 31 down to 33-CUM_W of the generator state after its draw. Every later threshold adds 2^(CUM_W-1-LOG2N).
- R9: The generator holds a 32-bit state that is 1 after reset. `seed_load` loads `seed_value`, and a seed of 0 is replaced by 1. Each pass draws exactly once, in the cycle after the N-th weight. A draw changes state s into (s >> 1) XOR (s[0] ? 0xA3000000 : 0).
- R10: If `seed_load` is high in the same cycle as a pass's draw, the seed is loaded first. The draw then happens one cycle later, starting from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| w_valid | input | 1 | Weight stream valid |
| w_ready | output | 1 | Weight stream ready; low while busy |
| w_data | input | CUM_W | Normalized weight, 1.0 = 2^(CUM_W-1) |
| seed_load | input | 1 | Load `seed_value` into the generator |
| seed_value | input | 32 | Generator seed |
| idx_valid | output | 1 | Selected index available |
| idx_ready | input | 1 | Downstream accepts the index |
| idx_data | output | LOG2N | Index of the particle to copy |
| busy | output | 1 | Selection pass in progress |
| reg_init | output | 1 | One-cycle start pulse for regularization |

## Verification
Two functions can fall in the same cycle: loading a seed, and the single draw that a pass makes right after its last weight. The bench provokes this by raising `seed_load` in the cycle that directly follows the final weight handshake. It judges the result by the full index sequence, which must match thresholds derived from one step of the new seed. A second overlap is also exercised. A downstream stall on the last index can coincide with the end-of-pass pulse, so `reg_init` is checked to come exactly one cycle after that index's handshake, not earlier.

// File: rtl/pf_resamp_pkg.sv
package pf_resamp_pkg;

  localparam int unsigned   RNG_W    = 32;
  localparam logic [31:0]   RNG_TAPS = 32'hA300_0000;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DRAW,
    PH_WAIT,
    PH_SEARCH,
    PH_EMIT
  } phase_t;

  function automatic logic [RNG_W-1:0] rng_advance(input logic [RNG_W-1:0] s);
    return (s >> 1) ^ (s[0] ? RNG_TAPS : '0);
  endfunction

endpackage

// File: rtl/pf_cumsum_mem.sv
module pf_cumsum_mem #(
  parameter int LOG2N = 4,
  parameter int CUM_W = 32,
  localparam int N    = 1 << LOG2N,
  localparam int AW   = LOG2N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intake_open,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CUM_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CUM_W-1:0] rd_data,
  output logic             table_full
);

  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic [CUM_W-1:0] tbl [N];
  logic [CUM_W-1:0] run_sum;
  logic [CUM_W-1:0] sum_next;
  logic [AW-1:0]    wptr;
  logic             take;

  assign wr_ready   = intake_open;
  assign take       = wr_valid && wr_ready;
  assign sum_next   = run_sum + wr_data;
  assign table_full = take && (wptr == LAST);
  assign rd_data    = tbl[rd_addr];

  always_ff @(posedge clk) begin
    if (take) tbl[wptr] <= sum_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sum <= '0;
      wptr    <= '0;
    end else if (take) begin
      if (wptr == LAST) begin
        run_sum <= '0;
        wptr    <= '0;
      end else begin
        run_sum <= sum_next;
        wptr    <= wptr + AW'(1);
      end
    end
  end

  // The table may only be written while intake is open (R2)
  assert_no_write_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !intake_open |=> $stable(wptr) && $stable(run_sum));

endmodule

// File: rtl/pf_lfsr_src.sv
module pf_lfsr_src
  import pf_resamp_pkg::*;
#(
  parameter int FRAC_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [RNG_W-1:0]  seed_value,
  input  logic              draw_req,
  output logic              draw_valid,
  output logic [FRAC_W-1:0] draw_frac
);

  logic [RNG_W-1:0] state;
  logic             pend;

  assign draw_frac = state[RNG_W-1 -: FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RNG_W'(1);
      pend       <= 1'b0;
      draw_valid <= 1'b0;
    end else begin
      draw_valid <= 1'b0;
      if (seed_load) begin
        state <= (seed_value == '0) ? RNG_W'(1) : seed_value;
        pend  <= pend | draw_req;
      end else if (draw_req || pend) begin
        state      <= rng_advance(state);
        pend       <= 1'b0;
        draw_valid <= 1'b1;
      end
    end
  end

  // The generator state never reaches zero (R9)
  assert_state_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // A seed arriving together with a draw postpones the draw by one cycle (R10)
  assert_seed_defers_draw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load && draw_req |=> !draw_valid);

endmodule

// File: rtl/pf_threshold.sv
module pf_threshold #(
  parameter int LOG2N = 4,
  parameter int CUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CUM_W-2:0] rand_frac,
  input  logic             advance,
  output logic [CUM_W-1:0] u_cur
);

  localparam logic [CUM_W-1:0] STEP = CUM_W'(1) << (CUM_W - 1 - LOG2N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_cur <= '0;
    end else if (load) begin
      u_cur <= {1'b0, rand_frac} >> LOG2N;
    end else if (advance) begin
      u_cur <= u_cur + STEP;
    end
  end

  // A new pass start and a slot step never coincide (R8)
  assert_load_step_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && advance));

endmodule

// File: rtl/pf_search_ctl.sv
module pf_search_ctl
  import pf_resamp_pkg::*;
#(
  parameter int LOG2N = 4,
  parameter int CUM_W = 32,
  localparam int N    = 1 << LOG2N,
  localparam int AW   = LOG2N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pass_start,
  output logic             draw_req,
  input  logic             draw_valid,
  output logic [AW-1:0]    rd_addr,
  input  logic [CUM_W-1:0] cum_val,
  input  logic [CUM_W-1:0] u_cur,
  output logic             next_u,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_idx,
  output logic             busy,
  output logic             reg_init
);

  localparam logic [AW-1:0] LAST = AW'(N - 1);

  phase_t      ph;
  logic [AW-1:0] ptr;
  logic [AW-1:0] slot;
  logic          step_on;

  assign rd_addr  = ptr;
  assign draw_req = (ph == PH_DRAW);
  assign busy     = (ph != PH_IDLE);
  assign next_u   = (ph == PH_EMIT) && out_ready && (slot != LAST);
  assign step_on  = (u_cur > cum_val) && (ptr != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      ptr       <= '0;
      slot      <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      reg_init  <= 1'b0;
    end else begin
      reg_init <= 1'b0;
      unique case (ph)
        PH_IDLE:   if (pass_start) ph <= PH_DRAW;
        PH_DRAW:   ph <= PH_WAIT;
        PH_WAIT: begin
          if (draw_valid) begin
            ptr  <= '0;
            slot <= '0;
            ph   <= PH_SEARCH;
          end
        end
        PH_SEARCH: begin
          if (step_on) begin
            ptr <= ptr + AW'(1);
          end else begin
            out_valid <= 1'b1;
            out_idx   <= ptr;
            ph        <= PH_EMIT;
          end
        end
        PH_EMIT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            if (slot == LAST) begin
              reg_init <= 1'b1;
              ph       <= PH_IDLE;
            end else begin
              slot <= slot + AW'(1);
              ph   <= PH_SEARCH;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // An emitted index covers its threshold, unless it is the last particle (R3, R5)
  assert_select_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (u_cur <= cum_val) || (out_idx == LAST));

  // The pointer never moves backward within a pass (R4)
  assert_ptr_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SEARCH || ph == PH_EMIT) &&
    ($past(ph) == PH_SEARCH || $past(ph) == PH_EMIT) |-> ptr >= $past(ptr));

  // A held index stays put under back-pressure (R6)
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx));

  // The end-of-pass pulse lasts one cycle (R7)
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_init |=> !reg_init);

  // busy only falls together with the end-of-pass pulse (R7)
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> reg_init);

endmodule

// File: rtl/pf_resampler.sv
module pf_resampler #(
  parameter int LOG2N = 4,
  parameter int CUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             w_valid,
  output logic             w_ready,
  input  logic [CUM_W-1:0] w_data,
  input  logic             seed_load,
  input  logic [31:0]      seed_value,
  output logic             idx_valid,
  input  logic             idx_ready,
  output logic [LOG2N-1:0] idx_data,
  output logic             busy,
  output logic             reg_init
);

  localparam int FRAC_W = CUM_W - 1;

  logic             table_full;
  logic [LOG2N-1:0] rd_addr;
  logic [CUM_W-1:0] cum_val;
  logic             draw_req;
  logic             draw_valid;
  logic [FRAC_W-1:0] draw_frac;
  logic [CUM_W-1:0] u_cur;
  logic             next_u;

  pf_cumsum_mem #(.LOG2N(LOG2N), .CUM_W(CUM_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .intake_open (!busy),
    .wr_valid    (w_valid),
    .wr_ready    (w_ready),
    .wr_data     (w_data),
    .rd_addr     (rd_addr),
    .rd_data     (cum_val),
    .table_full  (table_full)
  );

  pf_lfsr_src #(.FRAC_W(FRAC_W)) u_rng (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .draw_req   (draw_req),
    .draw_valid (draw_valid),
    .draw_frac  (draw_frac)
  );

  pf_threshold #(.LOG2N(LOG2N), .CUM_W(CUM_W)) u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (draw_valid),
    .rand_frac (draw_frac),
    .advance   (next_u),
    .u_cur     (u_cur)
  );

  pf_search_ctl #(.LOG2N(LOG2N), .CUM_W(CUM_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass_start (table_full),
    .draw_req   (draw_req),
    .draw_valid (draw_valid),
    .rd_addr    (rd_addr),
    .cum_val    (cum_val),
    .u_cur      (u_cur),
    .next_u     (next_u),
    .out_valid  (idx_valid),
    .out_ready  (idx_ready),
    .out_idx    (idx_data),
    .busy       (busy),
    .reg_init   (reg_init)
  );

  // The intake stream is closed for the whole pass (R2)
  assert_intake_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !w_ready);

  // No index is offered outside a pass (R7)
  assert_idx_in_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> busy);

endmodule

// File: tb/pf_resampler_tb.sv
module pf_resampler_tb;

  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int CUM_W = 32;
  localparam logic [31:0] STEP = 32'd1 << (CUM_W - 1 - LOG2N);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             w_valid = 1'b0;
  logic             w_ready;
  logic [CUM_W-1:0] w_data = '0;
  logic             seed_load = 1'b0;
  logic [31:0]      seed_value = '0;
  logic             idx_valid;
  logic             idx_ready = 1'b1;
  logic [LOG2N-1:0] idx_data;
  logic             busy;
  logic             reg_init;

  always #4 clk = ~clk;

  pf_resampler #(.LOG2N(LOG2N), .CUM_W(CUM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_ready(w_ready),
    .w_data(w_data), .seed_load(seed_load), .seed_value(seed_value),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
    .busy(busy), .reg_init(reg_init)
  );

  int          total = 0;
  int          bad = 0;
  int          exp_q[$];
  logic [31:0] model_rng = 32'd1;
  bit          prev_final = 0;
  int          passes_done = 0;
  int          rdy_mode = 0;
  int          cyc = 0;
  bit          hold_on = 0;
  int          hold_val = 0;
  logic [31:0] wv [N];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_step(input logic [31:0] s);
    logic [31:0] t;
    t = s >> 1;
    if (s[0]) t = t ^ 32'hA300_0000;
    return t;
  endfunction

  // Driver side of the scoreboard: expected index sequence (R3, R5, R8, R9)
  task automatic predict();
    logic [31:0] c [N];
    logic [31:0] acc;
    logic [31:0] u;
    int          p;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      acc  = acc + wv[i];
      c[i] = acc;
    end
    model_rng = model_step(model_rng);
    u = {1'b0, model_rng[31:1]} >> LOG2N;
    p = 0;
    for (int j = 0; j < N; j++) begin
      while (u > c[p] && p < N - 1) p++;
      exp_q.push_back(p);
      u = u + STEP;
    end
  endtask

  task automatic set_seed(input logic [31:0] s);
    @(posedge clk); #1;
    seed_load  = 1'b1;
    seed_value = s;
    @(posedge clk); #1;
    seed_load  = 1'b0;
    model_rng  = (s == 0) ? 32'd1 : s;
  endtask

  task automatic send_pass(input bit collide, input logic [31:0] cseed);
    int start_done;
    while (busy) @(negedge clk);
    start_done = passes_done;
    for (int i = 0; i < N; i++) begin
      @(posedge clk); #1;
      w_valid = 1'b1;
      w_data  = wv[i];
    end
    @(posedge clk); #1;
    w_valid = 1'b0;
    if (collide) begin
      seed_load  = 1'b1;
      seed_value = cseed;
      model_rng  = (cseed == 0) ? 32'd1 : cseed;
    end
    predict();
    @(posedge clk); #1;
    seed_load = 1'b0;
  endtask

  task automatic wait_pass(input int target);
    while (passes_done < target) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 idx_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  end

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_init || prev_final) begin
        chk(reg_init == prev_final, "R7 reg_init timing", reg_init, prev_final);
        if (reg_init) begin
          passes_done++;
          chk(busy == 1'b0, "R7 busy drop", busy, 0);
        end
      end
      prev_final = 0;
      if (hold_on)
        chk(idx_valid && idx_data == hold_val, "R6 held index", idx_data, hold_val);
      hold_on = 0;
      if (idx_valid && idx_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 extra index", idx_data, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(idx_data == e, "R3 selected index", idx_data, e);
          if (exp_q.size() == 0) prev_final = 1;
        end
      end else if (idx_valid) begin
        hold_on  = 1;
        hold_val = idx_data;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(w_ready == 1'b1, "R1 reset w_ready", w_ready, 1);
    chk(idx_valid == 1'b0, "R6 reset idx_valid", idx_valid, 0);
    chk(busy == 1'b0, "R2 reset busy", busy, 0);
    chk(reg_init == 1'b0, "R7 reset reg_init", reg_init, 0);

    // R1 R3 R9: uniform weights from reset seed state
    for (int i = 0; i < N; i++) wv[i] = STEP;
    send_pass(0, 0);
    wait_pass(1);

    // R3 R4: all mass on particle 5
    set_seed(32'h1234_5678);
    for (int i = 0; i < N; i++) wv[i] = (i == 5) ? 32'h8000_0000 : 32'd0;
    send_pass(0, 0);
    wait_pass(2);

    // R5: weights summing to a quarter, pointer saturates at N-1
    for (int i = 0; i < N; i++) wv[i] = STEP / 4;
    send_pass(0, 0);
    wait_pass(3);

    // R6 R8: skewed weights under back-pressure
    rdy_mode = 1;
    set_seed(32'h0);
    for (int i = 0; i < N; i++) wv[i] = ((i * 7) % 5) * (STEP / 2);
    send_pass(0, 0);
    wait_pass(4);

    // R10: seed load collides with the pass draw
    for (int i = 0; i < N; i++) wv[i] = (i % 2 == 0) ? STEP * 2 - STEP / 8 : STEP / 8;
    send_pass(1, 32'hDEAD_BEEF);
    // R2: weights offered during the pass are ignored
    w_valid = 1'b1;
    w_data  = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(w_ready == 1'b0, "R2 w_ready low while busy", w_ready, 0);
      chk(busy == 1'b1, "R2 busy high", busy, 1);
    end
    w_valid = 1'b0;
    wait_pass(5);

    // R1 R2: a clean pass after the ignored offers proves nothing was stored
    rdy_mode = 0;
    for (int i = 0; i < N; i++) wv[i] = (N - i) * (STEP / 9);
    send_pass(0, 0);
    wait_pass(6);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all indices emitted", exp_q.size(), 0);
    chk(passes_done == 6, "R7 pass count", passes_done, 6);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule